// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block lets two ports with unrelated clocks hand single words to each other without going through the FIFO. Each direction has its own one-word mailbox. Port A, on `clk_a`, fills mailbox 1 and drains mailbox 2. Port B, on `clk_b`, fills mailbox 2 and drains mailbox 1. A per-port select input decides whether a port operation goes to the mailbox or to the FIFO. Each port has its own write/read direction input, and the two ports use opposite polarities.

Each mailbox has an active-low full flag, which lives in the writing port's clock domain. A write drives the flag low. While the flag is low, further writes are refused, so the stored word cannot be overwritten before the other side has taken it. A read on the other port sends a toggle back through a synchronizer, and that toggle raises the flag again. Write and read events cross as toggles through multi-flop synchronizers. The stored word itself is not synchronized: it stays still from the moment it is written until its read comes back.

Port B's output selects between mailbox 1 and the FIFO read data, which enters the block as an input.

Top module: `mbx_pair`

## Requirements
- R1: When a port's select input is low, an enabled operation on that port is a FIFO operation. It leaves both mailboxes and both flags unchanged.
- R2: An enabled port A operation with `a_sel`=1 and `a_wr`=1 (write), accepted while `full1_n`=1, stores `a_wdata` as mailbox 1. `full1_n` reads 0 right after that `clk_a` edge.
- R3: While `full1_n`=0, port A writes to mailbox 1 are ignored. The stored word and the low flag are kept until port B reads the mailbox.
- R4: An enabled port B read (`b_sel`=1, `b_wr_n`=1) of a filled mailbox 1 raises `full1_n` again. This happens no later than SYNC_STAGES+2 `clk_a` cycles after the read edge.
- R5: Mailbox 2 mirrors mailbox 1 in the other direction. A port B write (`b_sel`=1, `b_wr_n`=0) while `full2_n`=1 stores `b_wdata` and drives `full2_n` low. Writes are ignored while the flag is low. A port A read (`a_sel`=1, `a_wr`=0) raises `full2_n` again within SYNC_STAGES+2 `clk_b` cycles.
- R6: `rst1_n` low sets `full1_n`=1 and clears mailbox 1 to zero. `rst2_n` low does the same for `full2_n` and mailbox 2. `prst_n` low does both. Each reset leaves the other mailbox untouched.
- R7: `b_rdata` equals mailbox 1 when `b_sel`=1 and equals `fifo_rdata` when `b_sel`=0.
- R8: `a_rdata` always presents the word held in mailbox 2.
- R9: A mailbox read on a port whose incoming mailbox is empty has no effect. The flag stays high, and a later write still drives it low and keeps it low until a real read.
- R10: A read-direction operation never writes a mailbox. Port A with `a_wr`=0 leaves `full1_n` high, and port B with `b_wr_n`=1 leaves `full2_n` high.
- R11: The full DATA_W-bit word that was written is what the reading port sees, with every bit intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst1_n | input | 1 | Asynchronous active-low reset of mailbox 1 and its flag |
| rst2_n | input | 1 | Asynchronous active-low reset of mailbox 2 and its flag |
| prst_n | input | 1 | Asynchronous active-low partial reset of both mailboxes |
| a_en | input | 1 | Port A operation enable |
| a_sel | input | 1 | Port A mailbox select (1 = mailbox, 0 = FIFO) |
| a_wr | input | 1 | Port A direction (1 = write, 0 = read) |
| a_wdata | input | DATA_W | Port A write word |
| a_rdata | output | DATA_W | Mailbox 2 word seen by port A |
| full1_n | output | 1 | Mailbox 1 full flag, active low, `clk_a` domain |
| b_en | input | 1 | Port B operation enable |
| b_sel | input | 1 | Port B mailbox select (1 = mailbox, 0 = FIFO) |
| b_wr_n | input | 1 | Port B direction (0 = write, 1 = read) |
| b_wdata | input | DATA_W | Port B write word |
| fifo_rdata | input | DATA_W | FIFO read data to be passed out on port B |
| b_rdata | output | DATA_W | Port B output word: mailbox 1 or FIFO data |
| full2_n | output | 1 | Mailbox 2 full flag, active low, `clk_b` domain |

## Verification
A flag falls in the writer's own domain. It is due at the first half-cycle after the write edge, and the bench samples it at the next falling edge. A flag returns high only after the read toggle has crossed. The bench therefore waits SYNC_STAGES+2 cycles of the writer's clock before it expects the flag high. It also waits that long in the reader's clock before issuing a read, so the data is known to have arrived. The output mux and `a_rdata` are combinational and are checked one time step after their inputs change. Negative checks (blocked writes, empty reads, FIFO-mode operations) are sampled after the same windows, so a wrong change would already have become visible.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_FIFO  = 2'd1,
      OP_MB_WR = 2'd2,
      OP_MB_RD = 2'd3
   } mbx_op_e;

   // Normalised port operation; direction already in "1 = write" sense.
   function automatic mbx_op_e port_op(input logic en, input logic sel, input logic is_wr);
      if (!en)  return OP_IDLE;
      if (!sel) return OP_FIFO;
      return is_wr ? OP_MB_WR : OP_MB_RD;
   endfunction

endpackage

// File: rtl/mbx_tog_sync.sv
module mbx_tog_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mbx_tog_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
   parameter int W      = 36,
   parameter int STAGES = 2
) (
   input  logic         wclk,
   input  logic         rclk,
   input  logic         rst_n,
   input  logic         wr_req,
   input  logic [W-1:0] wdata,
   input  logic         rd_req,
   output logic [W-1:0] word,
   output logic         full,
   output logic         avail
);
   logic wtog, rtog;
   logic wtog_in_r, rtog_in_w;

   // writer domain: word and write toggle
   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wtog <= 1'b0;
         word <= '0;
      end else if (wr_req && !full) begin
         wtog <= ~wtog;
         word <= wdata;
      end
   end

   assign full = wtog ^ rtog_in_w;

   // reader domain: read toggle, only on a pending word
   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)                rtog <= 1'b0;
      else if (rd_req && avail)  rtog <= ~rtog;
   end

   assign avail = wtog_in_r ^ rtog;

   mbx_tog_sync #(.STAGES(STAGES)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wtog), .q(wtog_in_r));

   mbx_tog_sync #(.STAGES(STAGES)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rtog), .q(rtog_in_w));
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
   import mbx_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_a,
   input  logic              clk_b,
   input  logic              rst1_n,
   input  logic              rst2_n,
   input  logic              prst_n,
   input  logic              a_en,
   input  logic              a_sel,
   input  logic              a_wr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              full1_n,
   input  logic              b_en,
   input  logic              b_sel,
   input  logic              b_wr_n,
   input  logic [DATA_W-1:0] b_wdata,
   input  logic [DATA_W-1:0] fifo_rdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              full2_n
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mbx_pair: DATA_W must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mbx_pair: SYNC_STAGES must be at least 2");
      end
   endgenerate

   mbx_op_e op_a, op_b;
   logic rst_m1_n, rst_m2_n;
   logic [DATA_W-1:0] mail1_q, mail2_q;
   logic full1, full2, avail1, avail2;

   assign op_a = port_op(a_en, a_sel, a_wr);
   assign op_b = port_op(b_en, b_sel, ~b_wr_n);

   assign rst_m1_n = rst1_n & prst_n;
   assign rst_m2_n = rst2_n & prst_n;

   // mailbox 1: A -> B
   mbx_chan #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_mb1 (
      .wclk(clk_a), .rclk(clk_b), .rst_n(rst_m1_n),
      .wr_req(op_a == OP_MB_WR), .wdata(a_wdata),
      .rd_req(op_b == OP_MB_RD),
      .word(mail1_q), .full(full1), .avail(avail1));

   // mailbox 2: B -> A
   mbx_chan #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_mb2 (
      .wclk(clk_b), .rclk(clk_a), .rst_n(rst_m2_n),
      .wr_req(op_b == OP_MB_WR), .wdata(b_wdata),
      .rd_req(op_a == OP_MB_RD),
      .word(mail2_q), .full(full2), .avail(avail2));

   assign full1_n = ~full1;
   assign full2_n = ~full2;
   assign a_rdata = mail2_q;
   assign b_rdata = b_sel ? mail1_q : fifo_rdata;
endmodule

// File: rtl/mbx_pair_chk.sv
module mbx_pair_chk #(
   parameter int W = 36
) (
   input logic         clk_a,
   input logic         clk_b,
   input logic         rst1_n,
   input logic         rst2_n,
   input logic         prst_n,
   input logic         a_en,
   input logic         a_sel,
   input logic         a_wr,
   input logic         b_en,
   input logic         b_sel,
   input logic         b_wr_n,
   input logic         full1_n,
   input logic         full2_n,
   input logic [W-1:0] mail1,
   input logic [W-1:0] mail2,
   input logic         avail1,
   input logic         avail2
);
   AST_WR_CLEARS_FLAG1: assert property (@(posedge clk_a) disable iff (!rst1_n || !prst_n)
      (a_en && a_sel && a_wr && full1_n) |=> !full1_n); // R2
   AST_FLAG1_FALL_NEEDS_WR: assert property (@(posedge clk_a) disable iff (!rst1_n || !prst_n)
      $fell(full1_n) |-> $past(a_en && a_sel && a_wr)); // R1
   AST_MAIL1_HELD_WHILE_FULL: assert property (@(posedge clk_a) disable iff (!rst1_n || !prst_n)
      !full1_n |=> $stable(mail1)); // R3
   AST_WR_CLEARS_FLAG2: assert property (@(posedge clk_b) disable iff (!rst2_n || !prst_n)
      (b_en && b_sel && !b_wr_n && full2_n) |=> !full2_n); // R5
   AST_FLAG2_FALL_NEEDS_WR: assert property (@(posedge clk_b) disable iff (!rst2_n || !prst_n)
      $fell(full2_n) |-> $past(b_en && b_sel && !b_wr_n)); // R10
   AST_MAIL2_HELD_WHILE_FULL: assert property (@(posedge clk_b) disable iff (!rst2_n || !prst_n)
      !full2_n |=> $stable(mail2)); // R5
   AST_AVAIL1_IMPLIES_FULL: assert property (@(posedge clk_b) disable iff (!rst1_n || !prst_n)
      avail1 |-> !full1_n); // R9
   AST_AVAIL2_IMPLIES_FULL: assert property (@(posedge clk_a) disable iff (!rst2_n || !prst_n)
      avail2 |-> !full2_n); // R9
   AST_RST_FLAG1_HIGH: assert property (@(posedge clk_a)
      (!rst1_n || !prst_n) |-> full1_n); // R6
   AST_RST_FLAG2_HIGH: assert property (@(posedge clk_b)
      (!rst2_n || !prst_n) |-> full2_n); // R6
endmodule

bind mbx_pair mbx_pair_chk #(.W(DATA_W)) u_chk (
   .clk_a(clk_a), .clk_b(clk_b), .rst1_n(rst1_n), .rst2_n(rst2_n), .prst_n(prst_n),
   .a_en(a_en), .a_sel(a_sel), .a_wr(a_wr),
   .b_en(b_en), .b_sel(b_sel), .b_wr_n(b_wr_n),
   .full1_n(full1_n), .full2_n(full2_n),
   .mail1(mail1_q), .mail2(mail2_q),
   .avail1(avail1), .avail2(avail2));

// File: tb/mbx_pair_test.sv
`timescale 1ns/1ps
module mbx_pair_test;
   localparam int W    = 36;
   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 2;

   logic clk_a = 1'b0, clk_b = 1'b0;
   always #4   clk_a = ~clk_a;   // 125 MHz
   always #5.5 clk_b = ~clk_b;

   logic rst1_n = 1'b0, rst2_n = 1'b0, prst_n = 1'b0;
   logic a_en = 1'b0, a_sel = 1'b0, a_wr = 1'b0;
   logic b_en = 1'b0, b_sel = 1'b0, b_wr_n = 1'b1;
   logic [W-1:0] a_wdata = '0, b_wdata = '0, fifo_rdata = '0;
   logic [W-1:0] a_rdata, b_rdata;
   logic full1_n, full2_n;

   int tests = 0, fails = 0;
   logic [W-1:0] exp1 = '0, exp2 = '0;

   mbx_pair #(.DATA_W(W), .SYNC_STAGES(SYNC)) uut (.*);

   function automatic logic [W-1:0] exp_bout(input logic sel, input logic [W-1:0] mail,
                                             input logic [W-1:0] fifo);
      return sel ? mail : fifo;
   endfunction

   function automatic logic [W-1:0] rnd_word();
      return {$urandom(), $urandom()};
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic a_cyc(input logic s, input logic w, input logic [W-1:0] d);
      @(negedge clk_a);
      a_en = 1'b1; a_sel = s; a_wr = w; a_wdata = d;
      @(negedge clk_a);
      a_en = 1'b0;
   endtask

   task automatic b_cyc(input logic s, input logic wn, input logic [W-1:0] d);
      @(negedge clk_b);
      b_en = 1'b1; b_sel = s; b_wr_n = wn; b_wdata = d;
      @(negedge clk_b);
      b_en = 1'b0;
   endtask

   task automatic wait_a(input int n); repeat (n) @(negedge clk_a); endtask
   task automatic wait_b(input int n); repeat (n) @(negedge clk_b); endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
   end

   initial begin
      logic [W-1:0] d, junk;
      void'($urandom(32'd20240611));
      #50.3;
      rst1_n = 1'b1; rst2_n = 1'b1; prst_n = 1'b1;
      wait_a(2);
      // reset state
      chk("R6 full1_n after reset", W'(full1_n), W'(1));
      chk("R6 full2_n after reset", W'(full2_n), W'(1));
      chk("R8 a_rdata after reset", a_rdata, '0);
      b_sel = 1'b1; #1;
      chk("R6 mailbox1 zero after reset", b_rdata, '0);

      // R9: empty reads change nothing
      b_cyc(1'b1, 1'b1, '0);
      wait_a(LAT + 2);
      chk("R9 empty B read keeps full1_n", W'(full1_n), W'(1));
      a_cyc(1'b1, 1'b0, '0);
      wait_b(LAT + 2);
      chk("R9 empty A read keeps full2_n", W'(full2_n), W'(1));

      // R1: FIFO-mode operations leave mailboxes alone
      a_cyc(1'b0, 1'b1, 36'h123456789);
      chk("R1 FIFO write keeps full1_n", W'(full1_n), W'(1));
      b_cyc(1'b0, 1'b0, 36'h987654321);
      chk("R1 FIFO write keeps full2_n", W'(full2_n), W'(1));
      b_sel = 1'b1; #1;
      chk("R1 mailbox1 untouched", b_rdata, '0);

      // R10: read-direction ops do not write
      a_cyc(1'b1, 1'b0, 36'hFFFFFFFFF);
      chk("R10 A read dir keeps full1_n", W'(full1_n), W'(1));
      b_cyc(1'b1, 1'b1, 36'hFFFFFFFFF);
      chk("R10 B read dir keeps full2_n", W'(full2_n), W'(1));

      // R2/R3/R4/R11 directed
      exp1 = 36'hA5A5A5A5A;
      a_cyc(1'b1, 1'b1, exp1);
      chk("R2 full1_n low after write", W'(full1_n), W'(0));
      a_cyc(1'b1, 1'b1, 36'h0F0F0F0F0);
      chk("R3 full1_n stays low", W'(full1_n), W'(0));
      wait_a(LAT + 2);
      chk("R9 no phantom read on flag1", W'(full1_n), W'(0));
      wait_b(LAT);
      b_sel = 1'b1; #1;
      chk("R3 blocked write kept word", b_rdata, exp1);
      chk("R11 full word at port B", b_rdata, exp1);
      b_cyc(1'b1, 1'b1, '0);
      wait_a(LAT);
      chk("R4 full1_n high after read", W'(full1_n), W'(1));

      // R5/R8 directed
      exp2 = 36'h5A5A5A5A5;
      b_cyc(1'b1, 1'b0, exp2);
      chk("R5 full2_n low after write", W'(full2_n), W'(0));
      b_cyc(1'b1, 1'b0, 36'h111111111);
      chk("R5 full2_n stays low", W'(full2_n), W'(0));
      wait_a(LAT);
      chk("R8 a_rdata shows mailbox2", a_rdata, exp2);
      a_cyc(1'b1, 1'b0, '0);
      wait_b(LAT);
      chk("R5 full2_n high after A read", W'(full2_n), W'(1));

      // R7 mux
      @(negedge clk_b);
      fifo_rdata = 36'hCAFEBEEF1; b_sel = 1'b0; #1;
      chk("R7 b_rdata is FIFO data", b_rdata, exp_bout(1'b0, exp1, fifo_rdata));
      b_sel = 1'b1; #1;
      chk("R7 b_rdata is mailbox1", b_rdata, exp_bout(1'b1, exp1, fifo_rdata));

      // random mix
      for (int i = 0; i < 30; i++) begin
         d = rnd_word();
         junk = rnd_word();
         if ($urandom_range(1, 0) == 1) begin
            a_cyc(1'b1, 1'b1, d); exp1 = d;
            chk("R2 random flag1 low", W'(full1_n), W'(0));
            if ($urandom_range(1, 0) == 1) a_cyc(1'b1, 1'b1, junk);
            wait_b(LAT);
            @(negedge clk_b);
            fifo_rdata = rnd_word(); b_sel = 1'($urandom_range(1, 0)); #1;
            chk("R7 random mux", b_rdata, exp_bout(b_sel, exp1, fifo_rdata));
            b_sel = 1'b1; #1;
            chk("R11 random word at B", b_rdata, exp1);
            b_cyc(1'b1, 1'b1, '0);
            wait_a(LAT);
            chk("R4 random flag1 high", W'(full1_n), W'(1));
         end else begin
            b_cyc(1'b1, 1'b0, d); exp2 = d;
            chk("R5 random flag2 low", W'(full2_n), W'(0));
            if ($urandom_range(1, 0) == 1) b_cyc(1'b1, 1'b0, junk);
            wait_a(LAT);
            chk("R8 random word at A", a_rdata, exp2);
            a_cyc(1'b1, 1'b0, '0);
            wait_b(LAT);
            chk("R5 random flag2 high", W'(full2_n), W'(1));
         end
      end

      // R6 resets
      a_cyc(1'b1, 1'b1, 36'h1111AAAA1);
      b_cyc(1'b1, 1'b0, 36'h2222BBBB2);
      wait_a(1);
      rst1_n = 1'b0; #30.3;
      chk("R6 rst1 raises full1_n", W'(full1_n), W'(1));
      chk("R6 rst1 keeps full2_n", W'(full2_n), W'(0));
      chk("R6 rst1 keeps mailbox2", a_rdata, 36'h2222BBBB2);
      b_sel = 1'b1; #1;
      chk("R6 rst1 clears mailbox1", b_rdata, '0);
      rst1_n = 1'b1;
      wait_a(2);
      prst_n = 1'b0; #30.3;
      chk("R6 prst raises full2_n", W'(full2_n), W'(1));
      chk("R6 prst clears mailbox2", a_rdata, '0);
      prst_n = 1'b1;
      wait_a(2);
      a_cyc(1'b1, 1'b1, 36'h333333333);
      b_cyc(1'b1, 1'b0, 36'h444444444);
      wait_a(1);
      rst2_n = 1'b0; #30.3;
      chk("R6 rst2 raises full2_n", W'(full2_n), W'(1));
      chk("R6 rst2 keeps full1_n", W'(full1_n), W'(0));
      rst2_n = 1'b1;
      wait_b(LAT);
      b_sel = 1'b1; #1;
      chk("R6 rst2 keeps mailbox1", b_rdata, 36'h333333333);
      b_cyc(1'b1, 1'b1, '0);
      wait_a(LAT);
      chk("R4 flag1 high after reset sequence", W'(full1_n), W'(1));

      summary();
   end
endmodule